// File: doc/BRIEF.md
# SPI Mode-3 Byte Target with System-Clock Oversampling

This block is the target (subordinate) side of an SPI link that exchanges one byte at a time in mode 3: SCLK rests high, each bit leaves on a falling edge and each bit is taken in on a rising edge. No flop in the block is clocked by SCLK. The serial clock, the data-in line and the active-low select are brought into the system clock domain through synchronizer chains. The SCLK edges are then found by comparing the current synchronized level with the level one cycle earlier.

One shift register serves both directions. Incoming bits enter at the low end while outgoing bits leave from the top. After eight rising edges the received byte is registered on a parallel output, and a strobe marks it for one system cycle. The local logic can hand over a byte to send with a load strobe at any time. The byte waits until the next byte boundary and is then copied into the shift register. When the target is not selected, its data-out line is left floating by dropping an output enable.

Top module: `spi_mode3_target`

## Requirements
- R1: While reset is held and right after it, `miso_oe_o`, `miso_o`, `rx_strobe_o` and `rx_byte_o` are all zero.
- R2: While selected, `miso_o` changes only in response to a synchronized SCLK falling edge, and it presents the outgoing byte MSB first, one bit per falling edge.
- R3: On each synchronized SCLK rising edge while selected, the `mosi_i` level is shifted into bit 0 of the shift register. After eight rising edges `rx_byte_o` holds the eight bits, with the first bit received in bit 7.
- R4: SCLK edges that occur while `sel_n_i` is high neither shift data nor produce `rx_strobe_o`, and they leave `rx_byte_o` unchanged.
- R5: `rx_strobe_o` is high for exactly one system cycle, in the cycle after the eighth rising edge of a byte. `rx_byte_o` changes only together with that strobe.
- R6: The bit count wraps after each byte, so consecutive bytes within one selection each produce their own strobe and received byte.
- R7: `miso_oe_o` is high only while the synchronized select is active. It is low once `sel_n_i` has been high for more than `SYNC_STAGES` cycles.
- R8: Releasing the select in the middle of a byte discards the partial byte: no strobe is produced, and the next selection starts again at bit 7.
- R9: A byte given with `tx_load_i` is copied into the shift register at the first falling edge of the next byte, so its bit 7 is the first bit sent. A load made during a byte does not disturb that byte and takes effect at the following one.
- R10: If no new byte has been loaded by a byte boundary, the shift register still holds the byte just received, and that byte is sent back during the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller, asynchronous |
| mosi_i | input | 1 | Serial data from the controller, asynchronous |
| sel_n_i | input | 1 | Active-low select, asynchronous |
| tx_byte_i | input | DATA_W | Byte to send next |
| tx_load_i | input | 1 | One-cycle strobe that accepts `tx_byte_i` |
| miso_o | output | 1 | Serial data to the controller |
| miso_oe_o | output | 1 | Output enable for `miso_o`; low means float |
| rx_byte_o | output | DATA_W | Last complete byte received |
| rx_strobe_o | output | 1 | One-cycle pulse marking a new `rx_byte_o` |

## Verification
The assertions assume that SCLK stays at or below a quarter of the system clock rate. Each SCLK level must therefore last long enough for the synchronized level to settle and for the edge compare to see it. They also assume that `mosi_i` is steady around each rising edge. The stimulus holds every SCLK half-period for five system cycles and changes the data line only together with a falling edge. It changes the select only while SCLK rests high, so no spurious edge can appear at a selection change.

// File: rtl/spi_tgt_pkg.sv
// Shared types for the SPI mode-3 target.
// Assumes: the three asynchronous inputs are grouped into one packed bundle
// so that the synchronizers can be generated in a loop.
package spi_tgt_pkg;

    localparam int PIN_CNT = 3;

    typedef struct packed {
        logic sclk;
        logic sel_n;
        logic mosi;
    } spi_pins_t;

    // Level each pin rests at when the bus is idle (mode 3: clock high).
    localparam spi_pins_t PIN_IDLE = '{sclk: 1'b1, sel_n: 1'b1, mosi: 1'b0};

endpackage

// File: rtl/spi_tgt_sync.sv
// Multi-flop synchronizer for one asynchronous input.
// Assumes: STAGES >= 2; the input may change at any time relative to clk.
// The reset value matches the idle level of the pin, so no false edge follows reset.
module spi_tgt_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain;

    // Shift the raw level through the chain of flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], async_i};
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/spi_tgt_edge.sv
// Edge finder for a synchronized level: one history flop, rise and fall strobes.
// Assumes: level_i is already in the clk domain and each level lasts two or more cycles.
module spi_tgt_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic rise_o,
    output logic fall_o
);

    logic hist;

    // Keep the previous synchronized level.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= RST_VAL;
        else        hist <= level_i;
    end

    assign rise_o =  level_i & ~hist;
    assign fall_o = ~level_i &  hist;

endmodule

// File: rtl/spi_tgt_shift.sv
// Bit engine of the mode-3 target: shared shift register, bit counter,
// outgoing bit, received-byte register and pending transmit byte.
// Assumes: rise_i and fall_i are single-cycle strobes that never coincide;
// selected_i is the synchronized, active-high select.
module spi_tgt_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              selected_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              tx_load_i,
    output logic              miso_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_strobe_o
);

    localparam int             CW   = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int             MSB  = DATA_W - 1;
    localparam logic [CW-1:0]  LAST = CW'(DATA_W - 1);

    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] pend;
    logic              pend_v;
    logic [CW-1:0]     cnt;
    logic              miso_q;
    logic [DATA_W-1:0] rx_q;
    logic              stb_q;

    // Advance the exchange on synchronized SCLK edges; park the transmit byte until a boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg  <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
            cnt    <= '0;
            miso_q <= 1'b0;
            rx_q   <= '0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (!selected_i) begin
                cnt <= '0;
            end else begin
                if (fall_i) begin
                    if (cnt == '0 && pend_v) begin
                        shreg  <= pend;
                        miso_q <= pend[MSB];
                        pend_v <= 1'b0;
                    end else begin
                        miso_q <= shreg[MSB];
                    end
                end
                if (rise_i) begin
                    shreg <= {shreg[MSB-1:0], mosi_i};
                    if (cnt == LAST) begin
                        cnt   <= '0;
                        rx_q  <= {shreg[MSB-1:0], mosi_i};
                        stb_q <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
            if (tx_load_i) begin
                pend   <= tx_byte_i;
                pend_v <= 1'b1;
            end
        end
    end

    assign miso_o      = miso_q;
    assign rx_byte_o   = rx_q;
    assign rx_strobe_o = stb_q;

endmodule

// File: rtl/spi_mode3_target.sv
// Top of the SPI mode-3 byte target, running wholly on clk.
// Assumes: clk runs at least four times faster than SCLK; the select changes
// only while SCLK rests high. miso_o is meant to drive a pad gated by miso_oe_o.
module spi_mode3_target #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              sel_n_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    input  logic              tx_load_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_strobe_o
);
    import spi_tgt_pkg::*;

    localparam logic [PIN_CNT-1:0] IDLE_VEC = PIN_IDLE;

    spi_pins_t          raw_pins;
    spi_pins_t          sync_pins;
    logic [PIN_CNT-1:0] raw_vec;
    logic [PIN_CNT-1:0] sync_vec;
    logic               sclk_rise;
    logic               sclk_fall;
    logic               selected;

    assign raw_pins = '{sclk: sclk_i, sel_n: sel_n_i, mosi: mosi_i};
    assign raw_vec  = raw_pins;

    // One synchronizer per asynchronous pin.
    for (genvar gi = 0; gi < PIN_CNT; gi++) begin : g_sync
        spi_tgt_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (IDLE_VEC[gi])
        ) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .async_i (raw_vec[gi]),
            .sync_o  (sync_vec[gi])
        );
    end

    assign sync_pins = sync_vec;
    assign selected  = ~sync_pins.sel_n;

    spi_tgt_edge #(
        .RST_VAL (PIN_IDLE.sclk)
    ) u_sclk_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_pins.sclk),
        .rise_o  (sclk_rise),
        .fall_o  (sclk_fall)
    );

    spi_tgt_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .selected_i  (selected),
        .rise_i      (sclk_rise),
        .fall_i      (sclk_fall),
        .mosi_i      (sync_pins.mosi),
        .tx_byte_i   (tx_byte_i),
        .tx_load_i   (tx_load_i),
        .miso_o      (miso_o),
        .rx_byte_o   (rx_byte_o),
        .rx_strobe_o (rx_strobe_o)
    );

    assign miso_oe_o = selected;

endmodule

// File: rtl/spi_mode3_target_chk.sv
// Property checker for spi_mode3_target, attached by bind.
// Assumes: the inputs respect the clock ratio given in the top header.
module spi_mode3_target_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic sel_n_i,
    input logic miso_o,
    input logic miso_oe_o,
    input logic rx_strobe_o,
    input logic sclk_rise,
    input logic sclk_fall,
    input logic selected
);

    logic [3:0] hi_run;

    // Count consecutive sampled cycles with the select released (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n)          hi_run <= '0;
        else if (!sel_n_i)   hi_run <= '0;
        else if (hi_run != 4'hF) hi_run <= hi_run + 4'd1;
    end

    AST_MISO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sclk_fall) |-> $stable(miso_o)); // R2
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe_o |=> !rx_strobe_o); // R5
    AST_STROBE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe_o |-> $past(sclk_rise)); // R5
    AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe_o |-> $past(selected)); // R4
    AST_OE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(hi_run) >= SYNC_STAGES) |-> !miso_oe_o); // R7

endmodule

bind spi_mode3_target spi_mode3_target_chk #(
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_n_i     (sel_n_i),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe_o),
    .rx_strobe_o (rx_strobe_o),
    .sclk_rise   (sclk_rise),
    .sclk_fall   (sclk_fall),
    .selected    (selected)
);

// File: tb/spi_mode3_target_bench.sv
// Self-checking bench: vector table of (transmit byte, incoming byte) pairs,
// then directed tests for reset, echo, mid-byte load, abort and ignored edges.
module spi_mode3_target_bench;

    localparam int HALF = 5;            // system cycles per SCLK half-period
    localparam int WDOG = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b1;
    logic       mosi = 1'b0;
    logic       sel_n = 1'b1;
    logic [7:0] tx_byte = '0;
    logic       tx_load = 1'b0;
    logic       miso;
    logic       miso_oe;
    logic [7:0] rx_byte;
    logic       rx_stb;

    int         n_checks = 0;
    int         n_fails = 0;
    int         stb_cnt = 0;
    int         stb_wide = 0;
    logic [7:0] last_rx = '0;
    logic       prev_stb = 1'b0;
    bit         done = 1'b0;

    // Each 16-bit entry: upper byte is loaded for transmit, lower byte is driven in.
    localparam logic [15:0] VEC [6] = '{16'hA53C, 16'hFF00, 16'h0081,
                                        16'h5AC3, 16'h0FF0, 16'h7E18};

    spi_mode3_target u_spi_mode3_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (sclk),
        .mosi_i      (mosi),
        .sel_n_i     (sel_n),
        .tx_byte_i   (tx_byte),
        .tx_load_i   (tx_load),
        .miso_o      (miso),
        .miso_oe_o   (miso_oe),
        .rx_byte_o   (rx_byte),
        .rx_strobe_o (rx_stb)
    );

    always #10 clk = ~clk;

    // Watch the receive strobe away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_stb) begin
                stb_cnt++;
                last_rx = rx_byte;
                if (prev_stb) stb_wide++;
            end
            prev_stb = rx_stb;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [7:0] b);
        @(negedge clk);
        tx_byte = b;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Run nbits SCLK cycles sending m MSB first; optionally load before bit load_at.
    task automatic xfer(input logic [7:0] m, input int nbits, input int load_at,
                        input logic [7:0] load_val, output logic [7:0] got);
        got = '0;
        for (int i = 0; i < nbits; i++) begin
            if (i == load_at) load(load_val);
            @(negedge clk);
            sclk = 1'b0;
            mosi = m[7-i];
            wait_cyc(HALF);
            got = {got[6:0], miso};
            sclk = 1'b1;
            wait_cyc(HALF);
        end
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        wait_cyc(WDOG);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] got;
        logic [7:0] got2;
        int         s0;
        wait_cyc(3);
        // R1: reset state while held
        check("R1 oe", miso_oe, 0);
        check("R1 strobe", rx_stb, 0);
        rst_n = 1'b1;
        wait_cyc(4);
        check("R1 miso", miso, 0);
        check("R1 rx_byte", rx_byte, 0);
        check("R7 oe idle", miso_oe, 0);

        // Table walk: one byte per selection
        foreach (VEC[k]) begin
            load(VEC[k][15:8]);
            sel_n = 1'b0;
            wait_cyc(6);
            check("R7 oe selected", miso_oe, 1);
            s0 = stb_cnt;
            xfer(VEC[k][7:0], 8, -1, 8'h00, got);
            wait_cyc(HALF);
            check("R2/R9 miso byte", got, VEC[k][15:8]);
            check("R3 rx byte", last_rx, VEC[k][7:0]);
            check("R5 strobe count", stb_cnt - s0, 1);
            sel_n = 1'b1;
            wait_cyc(6);
            check("R7 oe released", miso_oe, 0);
        end

        // R6 / R10: two bytes in one selection, only the first loaded
        load(8'h96);
        sel_n = 1'b0;
        wait_cyc(6);
        s0 = stb_cnt;
        xfer(8'h3B, 8, -1, 8'h00, got);
        xfer(8'hD4, 8, -1, 8'h00, got2);
        wait_cyc(HALF);
        check("R9 first byte", got, 8'h96);
        check("R10 echo byte", got2, 8'h3B);
        check("R6 two strobes", stb_cnt - s0, 2);
        check("R6 second rx", last_rx, 8'hD4);
        sel_n = 1'b1;
        wait_cyc(6);

        // R9: load during a byte is deferred to the next byte
        load(8'h11);
        sel_n = 1'b0;
        wait_cyc(6);
        xfer(8'hC6, 8, 3, 8'hEE, got);
        xfer(8'h2F, 8, -1, 8'h00, got2);
        wait_cyc(HALF);
        check("R9 current byte kept", got, 8'h11);
        check("R9 deferred byte", got2, 8'hEE);
        check("R3 rx after deferred", last_rx, 8'h2F);
        sel_n = 1'b1;
        wait_cyc(6);

        // R8: abort after three bits, then a fresh byte
        load(8'hC3);
        sel_n = 1'b0;
        wait_cyc(6);
        s0 = stb_cnt;
        xfer(8'hFF, 3, -1, 8'h00, got);
        check("R9 partial bits", got, 3'b110);
        sel_n = 1'b1;
        wait_cyc(6);
        check("R8 no strobe on abort", stb_cnt - s0, 0);
        load(8'h5D);
        sel_n = 1'b0;
        wait_cyc(6);
        xfer(8'h69, 8, -1, 8'h00, got);
        wait_cyc(HALF);
        check("R8 restart at bit 7 tx", got, 8'h5D);
        check("R8 restart rx", last_rx, 8'h69);
        check("R8 one strobe", stb_cnt - s0, 1);
        sel_n = 1'b1;
        wait_cyc(6);

        // R4: edges while deselected are ignored
        s0 = stb_cnt;
        xfer(8'hA7, 8, -1, 8'h00, got);
        wait_cyc(HALF);
        check("R4 no strobe", stb_cnt - s0, 0);
        check("R4 rx unchanged", rx_byte, 8'h69);
        check("R7 oe stays low", miso_oe, 0);
        check("R5 strobe width", stb_wide, 0);

        // R1: reset again clears outputs
        rst_n = 1'b0;
        wait_cyc(3);
        check("R1 rx after reset", rx_byte, 0);
        check("R1 miso after reset", miso, 0);
        rst_n = 1'b1;
        wait_cyc(2);
        finish_run();
    end

endmodule